// File: doc/BRIEF.md
# Power-Control Register Access Gate

This block sits on the request path between a bus master and a power-control register file. Every request arrives with two attribute bits: a secure flag and a privileged flag. For each request the gate decides at once whether the access may reach the register file. The decision uses a per-function secure mask, two privilege bits (one that governs secure functions and one that governs non-secure functions) and a backup-domain write-unlock bit. An allowed request is passed through in the same cycle. A refused write is dropped. A refused read returns zero. A refused request of either kind raises an error strobe for that one cycle only.

The three configuration words are held inside the gate and reached through the same request port. These are the secure mask, the privilege word and the unlock word. Every other mapped word address belongs to one function class and is forwarded to the register file. The register file answers reads combinationally in the same cycle. Word addresses used here:

| Class | Addresses | Secure-mask bit |
|---|---|---|
| low-power control | 0x00–0x01 | 12 |
| supply configuration and monitoring | 0x02–0x04 | 13 |
| backup domain | 0x05 (lockable), 0x06 | 14 |
| USB supply | 0x07 | 15 |
| I/O retention | 0x08 | 11 |
| wakeup pin i | 0x10 + i | i |

The local configuration words are:
- 0x20: secure mask.
- 0x21: privilege word. Bit 0 governs secure functions. Bit 1 governs non-secure functions.
- 0x22: unlock word, bit 0. It counts in the backup-domain class.

Top module: `pwr_access_filter`

## Requirements
- R1: After reset, the secure mask, both privilege bits and the unlock bit are 0, and reads of 0x20, 0x21 and 0x22 return 0.
- R2: An allowed access to a forwarded address drives the register-file request in the same cycle, with the same write flag, address and data. An allowed read returns the register file's data in that cycle.
- R3: A write to 0x05 is refused while the unlock bit (0x22 bit 0) is 0, and forwarded once it is 1. Reads of 0x05 are not affected by the lock.
- R4: When a function's secure-mask bit is 1, non-secure reads and writes to that function are refused.
- R5: When a function's secure-mask bit is 0, both secure and non-secure accesses to it are accepted.
- R6: Each wakeup pin i is protected only by mask bit i, independently of the other pins.
- R7: The secure mask accepts writes only from secure accesses. Only bits 0..N_WAKE-1 and bits 11..15 are stored; all other bits read 0.
- R8: Bit 0 of the privilege word changes only on a write that is both secure and privileged. Bit 1 changes on any privileged write. An unprivileged write to 0x21 is refused. A privileged non-secure write to 0x21 is accepted but leaves bit 0 unchanged.
- R9: A function whose mask bit is 1 follows privilege bit 0, and a function whose mask bit is 0 follows privilege bit 1. When the governing bit is 1, unprivileged accesses are refused. The secure mask word follows privilege bit 0. Reads of 0x21 are always allowed.
- R10: A refused access is not forwarded. If it is a read, it returns 0. It raises the error strobe for exactly the request cycle, and the error strobe is never high without a request.
- R11: Requests to unmapped addresses are refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| reqValid | input | 1 | request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | word address |
| reqWdata | input | DATA_W | write data |
| reqSecure | input | 1 | request carries secure attribute |
| reqPriv | input | 1 | request carries privileged attribute |
| rspRdata | output | DATA_W | read data, zero for writes and refused reads |
| accErr | output | 1 | refused-access strobe |
| fileValid | output | 1 | request forwarded to the register file |
| fileWrite | output | 1 | forwarded write flag |
| fileAddr | output | ADDR_W | forwarded address |
| fileWdata | output | DATA_W | forwarded write data |
| fileRdata | input | DATA_W | register file read data, same cycle |

## Verification
All internal state here is configuration: the mask, the two privilege bits and the unlock bit. A wrong value in any of them shows up on the very next request to an affected function. It appears as a missing or extra fileValid, a spurious or absent accErr, or a wrong readback of the configuration word. The reference model replays every request and compares all outputs in the request cycle. Because the random phase keeps rewriting the configuration between accesses, a corrupted bit is exposed within a few requests.

// File: rtl/pwrgate_pkg.sv
package pwrgate_pkg;

  localparam int MASK_W  = 16;
  localparam int SEC_RET = 11;
  localparam int SEC_LPM = 12;
  localparam int SEC_SCM = 13;
  localparam int SEC_BKP = 14;
  localparam int SEC_USB = 15;

  typedef enum logic [3:0] {
    FN_NONE, FN_WAKE, FN_RET, FN_LPM, FN_SCM, FN_BKP, FN_USB,
    FN_SECCFG, FN_PRIVCFG, FN_UNLKCFG
  } fn_e;

  typedef enum logic [2:0] {
    RD_ZERO, RD_FILE, RD_SEC, RD_PRIV, RD_UNLK
  } rdsel_e;

  typedef struct packed {
    logic   fwd;
    logic   deny;
    logic   wrSec;
    logic   wrSpriv;
    logic   wrNspriv;
    logic   wrUnlock;
    rdsel_e rdSel;
  } gate_strobe_t;

endpackage

// File: rtl/pwrgate_ctrl.sv
module pwrgate_ctrl
  import pwrgate_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int N_WAKE        = 8,
  parameter int LPM_BASE      = 0,
  parameter int LPM_CNT       = 2,
  parameter int SCM_BASE      = 2,
  parameter int SCM_CNT       = 3,
  parameter int BKP_LOCK_ADDR = 5,
  parameter int BKP_STAT_ADDR = 6,
  parameter int USB_ADDR      = 7,
  parameter int RET_ADDR      = 8,
  parameter int WAKE_BASE     = 16,
  parameter int SEC_ADDR      = 32,
  parameter int PRIV_ADDR     = 33,
  parameter int UNLK_ADDR     = 34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSecure,
  input  logic              reqPriv,
  input  logic [MASK_W-1:0] secMask,
  input  logic              sprivBit,
  input  logic              nsprivBit,
  input  logic              unlockBit,
  output gate_strobe_t      strobe
);

  int                addrInt;
  logic [N_WAKE-1:0] wakeHit;
  fn_e               fnSel;
  logic              secBit;
  logic              privBit;
  logic              secOk;
  logic              privOk;
  logic              lockHit;
  logic              allow;
  logic              isFile;
  logic              wakeSecure;

  always_comb addrInt = int'(reqAddr);

  for (genvar g = 0; g < N_WAKE; g++) begin : g_wake
    assign wakeHit[g] = (addrInt == WAKE_BASE + g);
  end

  assign wakeSecure = |(wakeHit & secMask[N_WAKE-1:0]);

  // function class decode and its secure-mask bit
  always_comb begin
    fnSel  = FN_NONE;
    secBit = 1'b0;
    if (addrInt >= LPM_BASE && addrInt < LPM_BASE + LPM_CNT) begin
      fnSel = FN_LPM;  secBit = secMask[SEC_LPM];
    end else if (addrInt >= SCM_BASE && addrInt < SCM_BASE + SCM_CNT) begin
      fnSel = FN_SCM;  secBit = secMask[SEC_SCM];
    end else if (addrInt == BKP_LOCK_ADDR || addrInt == BKP_STAT_ADDR) begin
      fnSel = FN_BKP;  secBit = secMask[SEC_BKP];
    end else if (addrInt == USB_ADDR) begin
      fnSel = FN_USB;  secBit = secMask[SEC_USB];
    end else if (addrInt == RET_ADDR) begin
      fnSel = FN_RET;  secBit = secMask[SEC_RET];
    end else if (|wakeHit) begin
      fnSel = FN_WAKE; secBit = wakeSecure;
    end else if (addrInt == SEC_ADDR) begin
      fnSel = FN_SECCFG;
    end else if (addrInt == PRIV_ADDR) begin
      fnSel = FN_PRIVCFG;
    end else if (addrInt == UNLK_ADDR) begin
      fnSel = FN_UNLKCFG; secBit = secMask[SEC_BKP];
    end
  end

  assign privBit = secBit ? sprivBit : nsprivBit;
  assign secOk   = !secBit || reqSecure;
  assign privOk  = !privBit || reqPriv;
  assign lockHit = reqWrite && (addrInt == BKP_LOCK_ADDR) && !unlockBit;
  assign isFile  = fnSel inside {FN_WAKE, FN_RET, FN_LPM, FN_SCM, FN_BKP, FN_USB};

  always_comb begin
    unique case (fnSel)
      FN_SECCFG:  allow = (!sprivBit || reqPriv) && (!reqWrite || reqSecure);
      FN_PRIVCFG: allow = !reqWrite || reqPriv;
      FN_UNLKCFG: allow = secOk && privOk;
      FN_NONE:    allow = 1'b0;
      default:    allow = secOk && privOk && !lockHit;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_ZERO;
    strobe.deny     = reqValid && !allow;
    strobe.fwd      = reqValid && allow && isFile;
    if (reqValid && allow && reqWrite) begin
      strobe.wrSec    = (fnSel == FN_SECCFG);
      strobe.wrUnlock = (fnSel == FN_UNLKCFG);
      strobe.wrNspriv = (fnSel == FN_PRIVCFG);
      strobe.wrSpriv  = (fnSel == FN_PRIVCFG) && reqSecure;
    end
    if (reqValid && allow && !reqWrite) begin
      unique case (fnSel)
        FN_SECCFG:  strobe.rdSel = RD_SEC;
        FN_PRIVCFG: strobe.rdSel = RD_PRIV;
        FN_UNLKCFG: strobe.rdSel = RD_UNLK;
        default:    strobe.rdSel = RD_FILE;
      endcase
    end
  end

  // R3: a locked backup write never reaches the register file
  p_bkp_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && addrInt == BKP_LOCK_ADDR && !unlockBit) |-> (!strobe.fwd && strobe.deny));

  // R4 / R6: a non-secure request to a secured wakeup pin is refused
  p_wake_secure_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqSecure && wakeSecure) |-> !strobe.fwd);

  // R11: unmapped requests are refused
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && fnSel == FN_NONE) |-> strobe.deny);

  // R8: privilege bit 0 changes only after a secure privileged write to the privilege word
  p_spriv_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sprivBit) |-> $past(reqValid && reqWrite && reqSecure && reqPriv && addrInt == PRIV_ADDR));

endmodule

// File: rtl/pwrgate_dpath.sv
module pwrgate_dpath
  import pwrgate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_WAKE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_strobe_t      str,
  input  logic [MASK_W-1:0] wrData,
  input  logic [DATA_W-1:0] fileRdata,
  output logic [MASK_W-1:0] secMask,
  output logic              sprivBit,
  output logic              nsprivBit,
  output logic              unlockBit,
  output logic [DATA_W-1:0] rspRdata
);

  localparam logic [MASK_W-1:0] WAKE_BITS = MASK_W'((32'd1 << N_WAKE) - 32'd1);
  localparam logic [MASK_W-1:0] FN_BITS   = MASK_W'((32'd1 << SEC_RET) | (32'd1 << SEC_LPM) |
                                                    (32'd1 << SEC_SCM) | (32'd1 << SEC_BKP) |
                                                    (32'd1 << SEC_USB));
  localparam logic [MASK_W-1:0] SEC_WMASK = WAKE_BITS | FN_BITS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secMask   <= '0;
      sprivBit  <= 1'b0;
      nsprivBit <= 1'b0;
      unlockBit <= 1'b0;
    end else begin
      if (str.wrSec)    secMask   <= wrData & SEC_WMASK;
      if (str.wrSpriv)  sprivBit  <= wrData[0];
      if (str.wrNspriv) nsprivBit <= wrData[1];
      if (str.wrUnlock) unlockBit <= wrData[0];
    end
  end

  always_comb begin
    rspRdata = '0;
    unique case (str.rdSel)
      RD_FILE: rspRdata = fileRdata;
      RD_SEC:  rspRdata[MASK_W-1:0] = secMask;
      RD_PRIV: rspRdata[1:0] = {nsprivBit, sprivBit};
      RD_UNLK: rspRdata[0] = unlockBit;
      default: rspRdata = '0;
    endcase
  end

  // R7: the secure mask holds unless a granted mask write was issued
  p_sec_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(str.wrSec) |-> $stable(secMask));

  // R8: privilege bit 0 holds unless the secure privileged strobe fired
  p_spriv_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(str.wrSpriv) |-> $stable(sprivBit));

  // R10: a refused access returns zero data
  p_deny_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    str.deny |-> (rspRdata == '0));

  // R2: a forwarded request never selects a local word
  p_fwd_file_r2: assert property (@(posedge clk) disable iff (!rstN)
    str.fwd |-> (str.rdSel inside {RD_FILE, RD_ZERO}));

endmodule

// File: rtl/pwr_access_filter.sv
module pwr_access_filter
  import pwrgate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_WAKE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqSecure,
  input  logic              reqPriv,
  output logic [DATA_W-1:0] rspRdata,
  output logic              accErr,
  output logic              fileValid,
  output logic              fileWrite,
  output logic [ADDR_W-1:0] fileAddr,
  output logic [DATA_W-1:0] fileWdata,
  input  logic [DATA_W-1:0] fileRdata
);

  gate_strobe_t      strobe;
  logic [MASK_W-1:0] secMask;
  logic              sprivBit;
  logic              nsprivBit;
  logic              unlockBit;

  pwrgate_ctrl #(.ADDR_W(ADDR_W), .N_WAKE(N_WAKE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqSecure (reqSecure),
    .reqPriv   (reqPriv),
    .secMask   (secMask),
    .sprivBit  (sprivBit),
    .nsprivBit (nsprivBit),
    .unlockBit (unlockBit),
    .strobe    (strobe)
  );

  pwrgate_dpath #(.DATA_W(DATA_W), .N_WAKE(N_WAKE)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .str       (strobe),
    .wrData    (reqWdata[MASK_W-1:0]),
    .fileRdata (fileRdata),
    .secMask   (secMask),
    .sprivBit  (sprivBit),
    .nsprivBit (nsprivBit),
    .unlockBit (unlockBit),
    .rspRdata  (rspRdata)
  );

  assign fileValid = strobe.fwd;
  assign fileWrite = reqWrite;
  assign fileAddr  = reqAddr;
  assign fileWdata = reqWdata;
  assign accErr    = strobe.deny;

  // R10: the error strobe only accompanies a request and never a forward
  p_err_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (reqValid && !fileValid));

endmodule

// File: tb/pwr_access_filter_tb.sv
module pwr_access_filter_tb;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int N_WAKE = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqSecure = 1'b0;
  logic              reqPriv = 1'b0;
  logic [DATA_W-1:0] rspRdata;
  logic              accErr;
  logic              fileValid;
  logic              fileWrite;
  logic [ADDR_W-1:0] fileAddr;
  logic [DATA_W-1:0] fileWdata;
  logic [DATA_W-1:0] fileRdata;

  logic [DATA_W-1:0] mem [0:63];
  assign fileRdata = mem[fileAddr[5:0]];

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  // reference configuration state
  int  mMask = 0;
  bit  mSp = 1'b0;
  bit  mNp = 1'b0;
  bit  mUnlk = 1'b0;

  always #5 clk = ~clk;

  pwr_access_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_WAKE(N_WAKE)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqSecure(reqSecure), .reqPriv(reqPriv), .rspRdata(rspRdata),
    .accErr(accErr), .fileValid(fileValid), .fileWrite(fileWrite), .fileAddr(fileAddr),
    .fileWdata(fileWdata), .fileRdata(fileRdata)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 file, 2 mask word, 3 privilege word, 4 unlock word
  function automatic void classify(input int addr, output int kind, output int sbit);
    kind = 1; sbit = -1;
    if (addr <= 1)                               sbit = 12;
    else if (addr <= 4)                          sbit = 13;
    else if (addr <= 6)                          sbit = 14;
    else if (addr == 7)                          sbit = 15;
    else if (addr == 8)                          sbit = 11;
    else if (addr >= 16 && addr < 16 + N_WAKE)   sbit = addr - 16;
    else if (addr == 32)                         kind = 2;
    else if (addr == 33)                         kind = 3;
    else if (addr == 34) begin                   kind = 4; sbit = 14; end
    else                                         kind = 0;
  endfunction

  task automatic access(input bit wr, input int addr, input logic [DATA_W-1:0] data,
                        input bit sec, input bit prv, input string tag);
    int  kind;
    int  sbit;
    bit  sBit;
    bit  pBit;
    bit  allow;
    bit  fwdExp;
    logic [DATA_W-1:0] rdExp;
    classify(addr, kind, sbit);
    sBit = (sbit >= 0) ? mMask[sbit] : 1'b0;
    pBit = sBit ? mSp : mNp;
    case (kind)
      1: allow = (!sBit || sec) && (!pBit || prv) && !(wr && addr == 5 && !mUnlk);
      2: allow = (!mSp || prv) && (!wr || sec);
      3: allow = !wr || prv;
      4: allow = (!sBit || sec) && (!pBit || prv);
      default: allow = 1'b0;
    endcase
    fwdExp = allow && (kind == 1);
    rdExp = '0;
    if (allow && !wr) begin
      case (kind)
        1: rdExp = mem[addr];
        2: rdExp = DATA_W'(mMask);
        3: rdExp = {30'd0, mNp, mSp};
        4: rdExp = {31'd0, mUnlk};
        default: rdExp = '0;
      endcase
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(addr);
    reqWdata = data; reqSecure = sec; reqPriv = prv;
    #4;
    check(accErr == !allow, {tag, " accErr"}, accErr, !allow);
    check(fileValid == fwdExp, {tag, " fileValid"}, fileValid, fwdExp);
    if (fwdExp)
      check(fileWrite == wr && fileAddr == ADDR_W'(addr) && fileWdata == data,
            {tag, " forward fields"}, {fileWrite, fileAddr}, {wr, ADDR_W'(addr)});
    check(rspRdata == rdExp, {tag, " rdata"}, rspRdata, rdExp);
    @(posedge clk);
    if (allow && wr) begin
      case (kind)
        1: mem[addr] = data;
        2: mMask = int'(data[15:0]) & 32'hF800 & ~32'h0 | (int'(data[15:0]) & ((1 << N_WAKE) - 1));
        3: begin mNp = data[1]; if (sec) mSp = data[0]; end
        4: mUnlk = data[0];
        default: ;
      endcase
    end
    #1;
    reqValid = 1'b0;
    #1;
    check(accErr == 1'b0 && fileValid == 1'b0, {tag, " idle after request R10"}, accErr, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5000000 + i;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(accErr == 0 && fileValid == 0 && rspRdata == 0, "R1 idle outputs after reset", accErr, 0);

    access(0, 32, 0, 1, 1, "R1 mask word");
    access(0, 33, 0, 1, 1, "R1 privilege word");
    access(0, 34, 0, 1, 1, "R1 unlock word");

    access(1, 0, 32'h1234_5678, 1, 1, "R2 secure write");
    access(0, 0, 0, 1, 1, "R2 readback");
    access(1, 2, 32'hCAFE_0002, 0, 0, "R5 nonsecure unpriv write");
    access(0, 2, 0, 0, 0, "R5 nonsecure unpriv read");

    access(1, 5, 32'h0000_BEEF, 1, 1, "R3 locked write");
    access(0, 5, 0, 0, 0, "R3 read while locked");
    access(1, 34, 1, 0, 0, "R3 unlock");
    access(1, 5, 32'h0000_BEEF, 1, 1, "R3 unlocked write");
    access(0, 5, 0, 1, 1, "R3 readback");

    access(1, 32, 32'hFFFF_FFFF, 0, 1, "R7 nonsecure mask write");
    access(1, 32, 32'hFFFF_FFFF, 1, 0, "R7 secure mask write");
    access(0, 32, 0, 0, 0, "R7 mask readback");

    access(0, 0, 0, 0, 1, "R4 nonsecure read");
    access(1, 7, 32'h77, 0, 1, "R4 nonsecure write");
    access(0, 7, 0, 1, 0, "R4 secure read");

    access(1, 32, 32'h0000_0004, 1, 0, "R6 mask pin2 only");
    access(0, 18, 0, 0, 0, "R6 secured pin");
    access(1, 17, 32'h11, 0, 0, "R6 open pin");
    access(0, 17, 0, 0, 0, "R6 open pin readback");

    access(1, 33, 32'h3, 0, 1, "R8 nonsecure priv write");
    access(0, 33, 0, 0, 0, "R8 readback");
    access(1, 33, 32'h3, 1, 0, "R8 unpriv write");
    access(1, 33, 32'h1, 1, 1, "R8 secure priv write");
    access(0, 33, 0, 0, 0, "R8 readback both");

    access(0, 18, 0, 1, 0, "R9 secure fn unpriv");
    access(0, 18, 0, 1, 1, "R9 secure fn priv");
    access(0, 17, 0, 1, 0, "R9 open fn unpriv");
    access(0, 32, 0, 1, 0, "R9 mask word unpriv");
    access(1, 33, 32'h3, 1, 1, "R9 set both bits");
    access(0, 17, 0, 0, 0, "R9 open fn unpriv after bit1");
    access(0, 17, 0, 0, 1, "R9 open fn priv after bit1");

    access(0, 40, 0, 1, 1, "R11 unmapped read");
    access(1, 12, 32'h9, 1, 1, "R11 unmapped write");

    for (int i = 0; i < 600; i++) begin
      int pick;
      int addr;
      pick = $urandom_range(0, 15);
      case (pick)
        0, 1, 2: addr = $urandom_range(0, 8);
        3, 4, 5: addr = 16 + $urandom_range(0, N_WAKE - 1);
        6, 7:    addr = 32;
        8, 9:    addr = 33;
        10, 11:  addr = 34;
        12, 13:  addr = 5;
        default: addr = $urandom_range(0, 63);
      endcase
      access(bit'($urandom_range(0, 1)), addr, $urandom,
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R10 random mix");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule